// File: doc/BRIEF.md
# Power-On Reset Supervisor

This block is the digital sequencer that decides when a programmable device may leave reset. External voltage comparators report a good/bad flag for the core supply, the analog supply, the I/O supply of each configuration bank and, in the battery-backed variant, a battery supply. The block synchronizes and debounces every flag. It holds the device in reset until the whole power-up set is good, then waits out a power-on delay. A mode pin picks the delay from a short range or a long range. After the delay it starts configuration, unless an external active-low hold-off request is asserted.

When the configuration engine signals completion, the block enters user mode and opens the global output-enable gate for user I/O. In user mode only the core and analog supplies are watched. A loss on either one forces a brown-out reset and a full new power-up sequence. A sag on a configuration-bank supply is tolerated. The output enables of the configuration status pins bypass the gate, so those pins can drive at any time.

Top module: `por_supervisor`

## Requirements
- R1: While any power-up flag is not qualified good, `dev_reset_o` stays 1 and `cfg_start_o`, `user_mode_o` and `user_oe_o` stay 0. The power-up flags are `core_good_i`, `analog_good_i`, every bit of `bank_good_i`, and `batt_good_i` when `HAS_BATTERY` is 1.
- R2: Each supply flag passes a two-flop synchronizer. It counts as good only after `STABLE_CYCLES` consecutive synchronized high samples, and a single synchronized low sample makes it bad again. Latency from all flags rising together to `cfg_start_o` high is exactly `STABLE_CYCLES + 3 + delay` clock edges.
- R3: `fast_mode_i` high selects `FAST_DELAY_CYC` and low selects `STD_DELAY_CYC`. The mode is captured once, on entry to the delay. A change of `fast_mode_i` during the delay has no effect on its length.
- R4: A core or analog flag loss during the delay restarts the count from zero. A one-cycle core dropout followed by recovery gives `cfg_start_o` exactly `STABLE_CYCLES + 2 + delay` edges after the recovery.
- R5: While `cfg_req_n_i` is 0, configuration does not start, even after the delay has elapsed. Once it goes to 1 after the delay, `cfg_start_o` rises 3 edges later.
- R6: A configuration-bank flag loss during the delay returns the block to the supply wait. Configuration then needs the full qualification and delay again.
- R7: `cfg_start_o` is 1 only in the configuration phase, and `dev_reset_o` is 0 there. A `cfg_done_i` pulse in that phase moves the block to user mode on the next edge: `user_mode_o` = 1, `user_oe_o` = 1, `cfg_start_o` = 0.
- R8: `user_oe_o` is 1 only in user mode, and 0 in every reset, delay and configuration phase.
- R9: In configuration or user mode, a core or analog flag loss asserts `dev_reset_o` and drops `user_mode_o`, `user_oe_o` and `cfg_start_o`. Recovery then runs the full power-up sequence and ends in configuration, not in user mode.
- R10: In user mode, loss of bank or battery flags leaves `user_mode_o` and `user_oe_o` at 1.
- R11: `stat_oe_o` equals `stat_oe_i` in every phase, including reset.
- R12: With `HAS_BATTERY` = 0, `batt_good_i` is ignored and a missing battery flag does not hold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_good_i | input | 1 | Core supply in range (asynchronous) |
| analog_good_i | input | 1 | Analog supply in range (asynchronous) |
| bank_good_i | input | NUM_CFG_BANKS | Configuration-bank I/O supplies in range (asynchronous) |
| batt_good_i | input | 1 | Battery supply in range; used only when HAS_BATTERY = 1 |
| fast_mode_i | input | 1 | 1 selects the short power-on delay, 0 the long one |
| cfg_req_n_i | input | 1 | Active-low configuration hold-off |
| cfg_done_i | input | 1 | Configuration finished (synchronous to clk) |
| stat_oe_i | input | STAT_W | Output enables of configuration status pins |
| dev_reset_o | output | 1 | Device held in reset |
| cfg_start_o | output | 1 | Configuration may run |
| user_mode_o | output | 1 | Device in user mode |
| user_oe_o | output | 1 | Global gate for user I/O output enables |
| stat_oe_o | output | STAT_W | Status pin output enables, ungated |

## Verification
Assertions check on every cycle that a qualified flag rises only after a synchronized high sample and falls one edge after a low one. They also check that a core or analog loss in the delay zeroes the counter and that the captured mode stays fixed for the whole delay. Further per-cycle checks cover configuration starting only with banks good and hold-off released, user mode entered only on a done pulse, brown-out following any core or analog loss after configuration begins, and user mode persisting whenever those two supplies hold. Only the bench scenarios can show the exact release latencies for both delay modes. The same goes for rejection of short supply glitches, the restart and return-to-wait after mid-delay losses, the required full re-sequencing after a brown-out, and the battery variant.

// File: rtl/por_pkg.sv
`timescale 1ns/1ps
package por_pkg;
  typedef enum logic [2:0] {
    ST_POWER_WAIT = 3'd0,
    ST_POR_DELAY  = 3'd1,
    ST_CONFIG     = 3'd2,
    ST_USER       = 3'd3,
    ST_BROWNOUT   = 3'd4
  } por_state_e;
endpackage

// File: rtl/por_sync2.sv
`timescale 1ns/1ps
module por_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/por_supply_qual.sv
`timescale 1ns/1ps
module por_supply_qual #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic good_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic          sync_s;
  logic [CW-1:0] run_q, run_d;
  logic          good_q, good_d;

  por_sync2 #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_i),
    .q_o  (sync_s)
  );

  always_comb begin
    run_d  = run_q;
    good_d = good_q;
    if (!sync_s) begin
      run_d  = '0;
      good_d = 1'b0;
    end else if (run_q == LAST) begin
      good_d = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      good_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      good_q <= good_d;
    end
  end

  assign good_o = good_q;

  // R2: a flag only becomes good after a synchronized high sample
  p_good_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(sync_s));
  // R2: one synchronized low sample drops the flag on the next edge
  p_loss_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_s |=> !good_q);
endmodule

// File: rtl/por_supervisor.sv
`timescale 1ns/1ps
module por_supervisor
  import por_pkg::*;
#(
  parameter int CLK_HZ         = 200_000_000,
  parameter int FAST_DELAY_CYC = CLK_HZ / 1000 * 5,
  parameter int STD_DELAY_CYC  = CLK_HZ / 10,
  parameter int NUM_CFG_BANKS  = 4,
  parameter int HAS_BATTERY    = 1,
  parameter int STABLE_CYCLES  = 16,
  parameter int STAT_W         = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_good_i,
  input  logic                     analog_good_i,
  input  logic [NUM_CFG_BANKS-1:0] bank_good_i,
  input  logic                     batt_good_i,
  input  logic                     fast_mode_i,
  input  logic                     cfg_req_n_i,
  input  logic                     cfg_done_i,
  input  logic [STAT_W-1:0]        stat_oe_i,
  output logic                     dev_reset_o,
  output logic                     cfg_start_o,
  output logic                     user_mode_o,
  output logic                     user_oe_o,
  output logic [STAT_W-1:0]        stat_oe_o
);
  localparam int NF    = 3 + NUM_CFG_BANKS;
  localparam int MAXD  = (FAST_DELAY_CYC > STD_DELAY_CYC) ? FAST_DELAY_CYC : STD_DELAY_CYC;
  localparam int DW    = $clog2(MAXD + 1);
  localparam logic [DW-1:0] FAST_LAST = DW'(FAST_DELAY_CYC - 1);
  localparam logic [DW-1:0] STD_LAST  = DW'(STD_DELAY_CYC - 1);

  logic          rst_s_n;
  logic [1:0]    ctl_s;
  logic [NF-1:0] raw_flags, ok_flags;
  logic          core_ok, ana_ok, banks_ok, batt_ok, ca_ok, rest_ok;
  logic          fast_s, req_ok;

  por_state_e    state_q, state_d;
  logic [DW-1:0] dly_cnt_q, dly_cnt_d;
  logic          mode_q, mode_en, dly_last;

  // Reset: asserted asynchronously, released on the clock
  por_sync2 #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (1'b1),
    .q_o  (rst_s_n)
  );

  por_sync2 #(.W(2), .RST_VAL(2'b00)) u_ctl_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .d_i  ({fast_mode_i, cfg_req_n_i}),
    .q_o  (ctl_s)
  );
  assign fast_s = ctl_s[1];
  assign req_ok = ctl_s[0];

  assign raw_flags = {batt_good_i, bank_good_i, analog_good_i, core_good_i};

  for (genvar i = 0; i < NF; i++) begin : g_qual
    por_supply_qual #(.STABLE_CYCLES(STABLE_CYCLES)) u_qual (
      .clk   (clk),
      .rst_n (rst_s_n),
      .raw_i (raw_flags[i]),
      .good_o(ok_flags[i])
    );
  end

  assign core_ok  = ok_flags[0];
  assign ana_ok   = ok_flags[1];
  assign banks_ok = &ok_flags[2 +: NUM_CFG_BANKS];

  if (HAS_BATTERY != 0) begin : g_batt
    assign batt_ok = ok_flags[NF-1];
  end else begin : g_no_batt
    assign batt_ok = 1'b1;
  end

  assign ca_ok   = core_ok & ana_ok;
  assign rest_ok = banks_ok & batt_ok;

  assign dly_last = (dly_cnt_q == (mode_q ? FAST_LAST : STD_LAST));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POWER_WAIT: if (ca_ok && rest_ok) state_d = ST_POR_DELAY;
      ST_POR_DELAY: begin
        if (!rest_ok)                          state_d = ST_POWER_WAIT;
        else if (ca_ok && dly_last && req_ok)  state_d = ST_CONFIG;
      end
      ST_CONFIG: begin
        if (!ca_ok)          state_d = ST_BROWNOUT;
        else if (cfg_done_i) state_d = ST_USER;
      end
      ST_USER:     if (!ca_ok) state_d = ST_BROWNOUT;
      ST_BROWNOUT: state_d = ST_POWER_WAIT;
      default:     state_d = ST_POWER_WAIT;
    endcase
  end

  always_comb begin
    dly_cnt_d = '0;
    if (state_q == ST_POR_DELAY && ca_ok)
      dly_cnt_d = dly_last ? dly_cnt_q : dly_cnt_q + 1'b1;
  end

  assign mode_en = (state_q == ST_POWER_WAIT) && (state_d == ST_POR_DELAY);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q   <= ST_POWER_WAIT;
      dly_cnt_q <= '0;
      mode_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      dly_cnt_q <= dly_cnt_d;
      if (mode_en) mode_q <= fast_s;
    end
  end

  assign dev_reset_o = !(state_q == ST_CONFIG || state_q == ST_USER);
  assign cfg_start_o = (state_q == ST_CONFIG);
  assign user_mode_o = (state_q == ST_USER);
  assign user_oe_o   = (state_q == ST_USER);
  assign stat_oe_o   = stat_oe_i;

  // R4: core/analog loss in the delay zeroes the counter
  p_delay_restart_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_POR_DELAY && !ca_ok) |=> (dly_cnt_q == '0));
  // R3: captured mode is fixed through the delay
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_POR_DELAY) |=> (state_q != ST_POR_DELAY || $stable(mode_q)));
  // R5, R6: configuration starts only with banks good and hold-off released
  p_cfg_gate_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(cfg_start_o) |-> $past(req_ok && banks_ok && batt_ok));
  // R7: user mode entered only on a done pulse
  p_user_entry_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(user_mode_o) |-> $past(cfg_done_i));
  // R9: core/analog loss after configuration begins forces brown-out
  p_brownout_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((state_q == ST_CONFIG || state_q == ST_USER) && !ca_ok) |=> (state_q == ST_BROWNOUT));
  // R10: user mode persists while core and analog hold
  p_bank_ignored_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_USER && ca_ok) |=> (state_q == ST_USER));
endmodule

// File: tb/por_supervisor_tb.sv
`timescale 1ns/1ps
module por_supervisor_tb;
  localparam int STB  = 3;
  localparam int FAST = 20;
  localparam int STD  = 50;
  localparam int NB   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic core, ana, batt, fast, req_n, cdone;
  logic [NB-1:0] banks;
  logic [2:0] stat;

  logic dev_reset, cfg_start, user_mode, user_oe;
  logic [2:0] stat_o;
  logic nb_reset, nb_start, nb_user, nb_oe;
  logic [2:0] nb_stat;

  int checks = 0;
  int fails  = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  por_supervisor #(.FAST_DELAY_CYC(FAST), .STD_DELAY_CYC(STD), .NUM_CFG_BANKS(NB),
                   .HAS_BATTERY(1), .STABLE_CYCLES(STB), .STAT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_good_i(core), .analog_good_i(ana),
    .bank_good_i(banks), .batt_good_i(batt), .fast_mode_i(fast),
    .cfg_req_n_i(req_n), .cfg_done_i(cdone), .stat_oe_i(stat),
    .dev_reset_o(dev_reset), .cfg_start_o(cfg_start), .user_mode_o(user_mode),
    .user_oe_o(user_oe), .stat_oe_o(stat_o));

  por_supervisor #(.FAST_DELAY_CYC(FAST), .STD_DELAY_CYC(STD), .NUM_CFG_BANKS(NB),
                   .HAS_BATTERY(0), .STABLE_CYCLES(STB), .STAT_W(3)) u_dut_nb (
    .clk(clk), .rst_n(rst_n), .core_good_i(core), .analog_good_i(ana),
    .bank_good_i(banks), .batt_good_i(1'b0), .fast_mode_i(fast),
    .cfg_req_n_i(req_n), .cfg_done_i(cdone), .stat_oe_i(stat),
    .dev_reset_o(nb_reset), .cfg_start_o(nb_start), .user_mode_o(nb_user),
    .user_oe_o(nb_oe), .stat_oe_o(nb_stat));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all(logic v);
    core = v; ana = v; banks = {NB{v}}; batt = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; set_all(1'b0); req_n = 1'b1; cdone = 1'b0; fast = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic wait_cfg(output int n);
    n = 0;
    while (!cfg_start && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    stat = 3'b000;
    @(negedge clk);
    do_reset();

    // R1, R8: reset state
    chk(dev_reset == 1'b1, "R1 reset held", dev_reset, 1);
    chk(cfg_start == 1'b0, "R1 no cfg start", cfg_start, 0);
    chk(user_mode == 1'b0, "R1 no user mode", user_mode, 0);
    chk(user_oe == 1'b0, "R8 oe off in reset", user_oe, 0);
    // R11: status enables pass through in reset
    for (int v = 0; v < 8; v++) begin
      stat = 3'(v); #1;
      chk(stat_o == 3'(v), "R11 stat passthrough reset", stat_o, v);
    end

    // R1: each missing flag holds reset; R12: battery ignored in variant
    for (int k = 0; k < 3 + NB; k++) begin
      do_reset();
      set_all(1'b1);
      if (k == 0) core = 1'b0;
      else if (k == 1) ana = 1'b0;
      else if (k < 2 + NB) banks[k-2] = 1'b0;
      else batt = 1'b0;
      cyc(80);
      chk(dev_reset == 1'b1, "R1 missing flag holds reset", dev_reset, 1);
      chk(cfg_start == 1'b0, "R1 missing flag no cfg", cfg_start, 0);
      if (k == 2 + NB)
        chk(nb_reset == 1'b0, "R12 battery ignored when absent", nb_reset, 0);
    end

    // R2, R3: exact latency in fast mode
    do_reset();
    set_all(1'b1);
    wait_cfg(n);
    chk(n == STB + 3 + FAST, "R2 R3 fast latency", n, STB + 3 + FAST);

    // R3: standard mode latency
    do_reset();
    fast = 1'b0;
    cyc(3);
    set_all(1'b1);
    wait_cfg(n);
    chk(n == STB + 3 + STD, "R3 standard latency", n, STB + 3 + STD);

    // R3: mode change during delay has no effect
    do_reset();
    set_all(1'b1);
    cyc(8);
    fast = 1'b0;
    wait_cfg(n);
    chk(8 + n == STB + 3 + FAST, "R3 mode sampled at entry", 8 + n, STB + 3 + FAST);

    // R2: short high pulses on core do not qualify
    do_reset();
    set_all(1'b1);
    core = 1'b0;
    cyc(5);
    repeat (10) begin
      core = 1'b1; cyc(2);
      core = 1'b0; cyc(1);
    end
    cyc(4);
    chk(dev_reset == 1'b1, "R2 glitches rejected", dev_reset, 1);
    core = 1'b1;
    wait_cfg(n);
    chk(n == STB + 3 + FAST, "R2 latency after glitches", n, STB + 3 + FAST);

    // R4: core dropout in delay restarts count
    do_reset();
    set_all(1'b1);
    cyc(15);
    core = 1'b0;
    cyc(1);
    core = 1'b1;
    wait_cfg(n);
    chk(n == STB + 2 + FAST, "R4 delay restart", n, STB + 2 + FAST);

    // R5: hold-off request
    do_reset();
    req_n = 1'b0;
    set_all(1'b1);
    cyc(FAST + 40);
    chk(cfg_start == 1'b0, "R5 hold-off blocks cfg", cfg_start, 0);
    chk(dev_reset == 1'b1, "R5 hold-off keeps reset", dev_reset, 1);
    req_n = 1'b1;
    wait_cfg(n);
    chk(n == 3, "R5 release latency", n, 3);

    // R6: bank loss during delay returns to supply wait
    do_reset();
    set_all(1'b1);
    cyc(10);
    banks[2] = 1'b0;
    cyc(FAST + 30);
    chk(cfg_start == 1'b0, "R6 bank loss blocks cfg", cfg_start, 0);
    banks[2] = 1'b1;
    wait_cfg(n);
    chk(n == STB + 3 + FAST, "R6 full resequence", n, STB + 3 + FAST);

    // R7, R8: configuration phase then user mode
    chk(dev_reset == 1'b0, "R7 reset released in cfg", dev_reset, 0);
    chk(user_oe == 1'b0, "R8 oe off in cfg", user_oe, 0);
    chk(user_mode == 1'b0, "R7 not user yet", user_mode, 0);
    cdone = 1'b1; cyc(1); cdone = 1'b0;
    chk(user_mode == 1'b1, "R7 user mode entered", user_mode, 1);
    chk(user_oe == 1'b1, "R7 oe enabled in user", user_oe, 1);
    chk(cfg_start == 1'b0, "R7 cfg start dropped", cfg_start, 0);

    // R11: passthrough in user mode
    for (int v = 0; v < 8; v++) begin
      stat = 3'(7 - v); #1;
      chk(stat_o == 3'(7 - v), "R11 stat passthrough user", stat_o, 7 - v);
    end

    // R10: bank and battery sag ignored in user mode
    banks = '0; batt = 1'b0;
    cyc(30);
    chk(user_mode == 1'b1, "R10 bank sag ignored", user_mode, 1);
    chk(user_oe == 1'b1, "R10 oe kept", user_oe, 1);
    banks = '1; batt = 1'b1;
    cyc(10);

    // R9: analog brown-out in user mode
    ana = 1'b0; cyc(1); ana = 1'b1;
    cyc(6);
    chk(user_mode == 1'b0, "R9 brownout leaves user", user_mode, 0);
    chk(user_oe == 1'b0, "R9 oe off after brownout", user_oe, 0);
    chk(dev_reset == 1'b1, "R9 reset asserted", dev_reset, 1);
    wait_cfg(n);
    chk(n < 2000, "R9 resequence reaches cfg", n, 0);
    chk(user_mode == 1'b0, "R9 resequence ends in cfg", user_mode, 0);

    // R9: core brown-out in configuration
    core = 1'b0;
    cyc(6);
    chk(dev_reset == 1'b1, "R9 core loss in cfg resets", dev_reset, 1);
    chk(cfg_start == 1'b0, "R9 cfg start dropped", cfg_start, 0);
    core = 1'b1;
    cyc(5);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule